// File: doc/BRIEF.md
# Ancillary Packet Formatter

This block turns a short stream of 9-bit payload words into a finished 10-bit ancillary data packet. The supplier starts at the secondary identifier and ends at the final user word. It raises a packet strobe one pixel-clock cycle ahead of the first word and drops it on the cycle of the last word. The block adds the three-word ancillary flag, a data identifier taken from a configuration input, and a trailing checksum. Every payload-derived word gets its tenth bit as the inverse of its ninth.

Each packet is written into one of two on-chip buffers. Once the packet is complete it is replayed as an unbroken burst on the output, with a valid strobe and an end marker on the checksum word. Packets leave in the order they finished. Packets that are too long are dropped and flagged. A packet that starts while no buffer is free is dropped silently.

Top module: `anc_packet_formatter`

## Requirements
- R1: During and after synchronous reset, with no packet offered, `anc_valid`, `anc_last` and `ovf_flag` are low.
- R2: A payload word is sampled in every cycle that follows a cycle with `pkt_en` high. The packet ends at the first sampled word that coincides with `pkt_en` low, so a strobe high for N cycles carries N words, and N = 1 is legal.
- R3: The identifier, each payload word and the checksum are emitted with bit 9 equal to the inverse of bit 8, and bits 8:0 unchanged.
- R4: Each packet is emitted as 10'h000, 10'h3FF, 10'h3FF, then the identifier, then the payload in arrival order, then the checksum. `anc_last` is high only on the checksum word.
- R5: Checksum bits 8:0 are the modulo-512 sum of bits 8:0 of the identifier and of every payload word.
- R6: The identifier is taken from `did_cfg` in the cycle the first payload word is sampled. Later changes to `did_cfg` do not affect that packet.
- R7: A packet of 255 payload words is emitted normally. When a 256th word is sampled, `ovf_flag` pulses for one cycle on the following cycle, and nothing of that packet is emitted.
- R8: Two packet buffers exist, and complete packets are emitted in completion order. A packet whose first word arrives while the next buffer in turn still holds an unsent packet is discarded entirely, without any flag.
- R9: From the leading 10'h000 to the checksum, `anc_valid` stays high in every cycle, and it is low for at least one cycle between packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_en | input | 1 | Packet strobe, leads the payload by one cycle |
| pkt_data | input | 9 | Payload word, secondary identifier first |
| did_cfg | input | 9 | Data identifier, bits 8:0 |
| anc_word | output | 10 | Formatted packet word |
| anc_valid | output | 1 | `anc_word` holds a packet word |
| anc_last | output | 1 | Current word is the checksum |
| ovf_flag | output | 1 | One-cycle pulse: a packet exceeded 255 payload words |

## Verification
The hardest state to reach is the silent drop in R8. It needs one packet still being replayed while a second is already parked in the other buffer, and a third starting within that window. The stimulus sends a 100-word packet and then two 3-word packets back to back. It expects exactly the first two on the output, and then confirms that a later packet still goes through. The overflow boundary is reached by driving exactly 255 and 256 words. Random packets with random identifiers and word values, including all-ones words that wrap the checksum, cover the formatting.

// File: rtl/anc_fmt_pkg.sv
package anc_fmt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADF0,
    PH_ADF1,
    PH_ADF2,
    PH_DID,
    PH_DATA,
    PH_CSUM
  } phase_t;

  localparam logic [9:0] FLAG_LO = 10'h000;
  localparam logic [9:0] FLAG_HI = 10'h3FF;

  function automatic logic [9:0] with_inv(input logic [8:0] w);
    return {~w[8], w};
  endfunction

endpackage

// File: rtl/anc_fmt_ram.sv
module anc_fmt_ram #(
  parameter int DW = 9,
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/anc_fmt_capture.sv
module anc_fmt_capture
  import anc_fmt_pkg::*;
#(
  parameter int MAX_WORDS = 255,
  parameter int CW        = $clog2(MAX_WORDS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pkt_en,
  input  logic [8:0]          pkt_data,
  input  logic [8:0]          did_cfg,
  input  logic                rel_vld,
  input  logic                rel_bank,
  output logic                ram_we,
  output logic [CW:0]         ram_waddr,
  output logic [8:0]          ram_wdata,
  output logic [1:0]          bank_full,
  output logic [1:0][8:0]     meta_did,
  output logic [1:0][CW-1:0]  meta_cnt,
  output logic [1:0][8:0]     meta_cs,
  output logic                ovf_pulse
);
  logic          en_q, en_qq, wb, keep_q, ovf_q;
  logic [CW-1:0] idx_q;
  logic [8:0]    cs_q, did_q;
  logic [1:0]    full_q;

  logic          first_w, last_w, keep_now, at_lim, wr_ok, commit;
  logic [CW-1:0] idx_now;
  logic [8:0]    cs_base, cs_next, did_now;

  always_comb begin
    first_w  = en_q & ~en_qq;
    last_w   = en_q & ~pkt_en;
    keep_now = first_w ? ~full_q[wb] : keep_q;
    idx_now  = first_w ? '0 : idx_q;
    cs_base  = first_w ? did_cfg : cs_q;
    did_now  = first_w ? did_cfg : did_q;
    at_lim   = (idx_now == CW'(MAX_WORDS));
    wr_ok    = en_q & keep_now & ~at_lim;
    commit   = wr_ok & last_w;
    cs_next  = cs_base + pkt_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      en_qq  <= 1'b0;
      wb     <= 1'b0;
      keep_q <= 1'b0;
      idx_q  <= '0;
      cs_q   <= '0;
      did_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      en_q  <= pkt_en;
      en_qq <= en_q;
      ovf_q <= en_q & keep_now & at_lim;
      if (en_q) begin
        keep_q <= keep_now & ~at_lim;
        did_q  <= did_now;
        cs_q   <= cs_next;
        if (wr_ok) idx_q <= idx_now + 1'b1;
      end
      if (commit) wb <= ~wb;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic          full_r;
    logic [8:0]    did_r, cs_r;
    logic [CW-1:0] cnt_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        full_r <= 1'b0;
        did_r  <= '0;
        cs_r   <= '0;
        cnt_r  <= '0;
      end else if (commit && (wb == 1'(b))) begin
        full_r <= 1'b1;
        did_r  <= did_now;
        cs_r   <= cs_next;
        cnt_r  <= idx_now + 1'b1;
      end else if (rel_vld && (rel_bank == 1'(b))) begin
        full_r <= 1'b0;
      end
    end

    assign full_q[b]   = full_r;
    assign meta_did[b] = did_r;
    assign meta_cs[b]  = cs_r;
    assign meta_cnt[b] = cnt_r;
  end

  assign ram_we    = wr_ok;
  assign ram_waddr = {wb, idx_now};
  assign ram_wdata = pkt_data;
  assign bank_full = full_q;
  assign ovf_pulse = ovf_q;

  // R8: payload is never written into a buffer still awaiting replay
  a_r8_write_free: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !full_q[wb]);

  // R7: an overflow pulse is never followed by that packet being stored
  a_r7_ovf_no_store: assert property (@(posedge clk) disable iff (rst)
    ovf_q && en_q |-> !ram_we);
endmodule

// File: rtl/anc_fmt_emitter.sv
module anc_fmt_emitter
  import anc_fmt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         bank_full,
  input  logic [1:0][8:0]    meta_did,
  input  logic [1:0][CW-1:0] meta_cnt,
  input  logic [1:0][8:0]    meta_cs,
  input  logic [8:0]         ram_rdata,
  output logic [CW:0]        ram_raddr,
  output logic               rel_vld,
  output logic               rel_bank,
  output logic [9:0]         anc_word,
  output logic               anc_valid,
  output logic               anc_last
);
  phase_t        ph, ph_d;
  logic          rb;
  logic [CW-1:0] ridx, cnt_l;
  logic [8:0]    did_l, cs_l;
  logic [9:0]    word_q;
  logic          valid_q, last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= PH_IDLE;
      ph_d    <= PH_IDLE;
      rb      <= 1'b0;
      ridx    <= '0;
      cnt_l   <= '0;
      did_l   <= '0;
      cs_l    <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      last_q  <= 1'b0;
    end else begin
      ph_d <= ph;
      unique case (ph)
        PH_IDLE: if (bank_full[rb]) begin
          did_l <= meta_did[rb];
          cnt_l <= meta_cnt[rb];
          cs_l  <= meta_cs[rb];
          ridx  <= '0;
          ph    <= PH_ADF0;
        end
        PH_ADF0: ph <= PH_ADF1;
        PH_ADF1: ph <= PH_ADF2;
        PH_ADF2: ph <= PH_DID;
        PH_DID:  ph <= PH_DATA;
        PH_DATA: begin
          ridx <= ridx + 1'b1;
          if (ridx == cnt_l - 1'b1) ph <= PH_CSUM;
        end
        PH_CSUM: begin
          rb <= ~rb;
          ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase

      valid_q <= (ph_d != PH_IDLE);
      last_q  <= (ph_d == PH_CSUM);
      unique case (ph_d)
        PH_ADF0: word_q <= FLAG_LO;
        PH_ADF1, PH_ADF2: word_q <= FLAG_HI;
        PH_DID:  word_q <= with_inv(did_l);
        PH_DATA: word_q <= with_inv(ram_rdata);
        PH_CSUM: word_q <= with_inv(cs_l);
        default: word_q <= '0;
      endcase
    end
  end

  assign ram_raddr = {rb, ridx};
  assign rel_vld   = (ph == PH_CSUM);
  assign rel_bank  = rb;
  assign anc_word  = word_q;
  assign anc_valid = valid_q;
  assign anc_last  = last_q;

  // R9: no hole inside a burst
  a_r9_no_gap: assert property (@(posedge clk) disable iff (rst)
    anc_valid && !anc_last |=> anc_valid);

  // R9: bursts are separated
  a_r9_gap_after_last: assert property (@(posedge clk) disable iff (rst)
    anc_last |=> !anc_valid);

  // R4: a burst opens with the flag sequence
  a_r4_opens_low: assert property (@(posedge clk) disable iff (rst)
    $rose(anc_valid) |-> anc_word == FLAG_LO);

  a_r4_then_high: assert property (@(posedge clk) disable iff (rst)
    $rose(anc_valid) |=> anc_word == FLAG_HI);

  // R8: only a filled buffer is ever released
  a_r8_release_held: assert property (@(posedge clk) disable iff (rst)
    rel_vld |-> bank_full[rel_bank]);
endmodule

// File: rtl/anc_packet_formatter.sv
module anc_packet_formatter
  import anc_fmt_pkg::*;
#(
  parameter int MAX_WORDS = 255
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pkt_en,
  input  logic [8:0] pkt_data,
  input  logic [8:0] did_cfg,
  output logic [9:0] anc_word,
  output logic       anc_valid,
  output logic       anc_last,
  output logic       ovf_flag
);
  localparam int CW = $clog2(MAX_WORDS + 1);
  localparam int AW = CW + 1;

  logic               ram_we;
  logic [AW-1:0]      ram_waddr, ram_raddr;
  logic [8:0]         ram_wdata, ram_rdata;
  logic [1:0]         bank_full;
  logic [1:0][8:0]    meta_did, meta_cs;
  logic [1:0][CW-1:0] meta_cnt;
  logic               rel_vld, rel_bank;

  anc_fmt_capture #(.MAX_WORDS(MAX_WORDS), .CW(CW)) u_capture (
    .clk       (clk),
    .rst       (rst),
    .pkt_en    (pkt_en),
    .pkt_data  (pkt_data),
    .did_cfg   (did_cfg),
    .rel_vld   (rel_vld),
    .rel_bank  (rel_bank),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .bank_full (bank_full),
    .meta_did  (meta_did),
    .meta_cnt  (meta_cnt),
    .meta_cs   (meta_cs),
    .ovf_pulse (ovf_flag)
  );

  anc_fmt_ram #(.DW(9), .AW(AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  anc_fmt_emitter #(.CW(CW)) u_emitter (
    .clk       (clk),
    .rst       (rst),
    .bank_full (bank_full),
    .meta_did  (meta_did),
    .meta_cnt  (meta_cnt),
    .meta_cs   (meta_cs),
    .ram_rdata (ram_rdata),
    .ram_raddr (ram_raddr),
    .rel_vld   (rel_vld),
    .rel_bank  (rel_bank),
    .anc_word  (anc_word),
    .anc_valid (anc_valid),
    .anc_last  (anc_last)
  );
endmodule

// File: tb/tb_anc_packet_formatter.sv
module tb_anc_packet_formatter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pkt_en = 1'b0;
  logic [8:0] pkt_data = '0;
  logic [8:0] did_cfg = '0;
  logic [9:0] anc_word;
  logic       anc_valid, anc_last, ovf_flag;

  always #2 clk = ~clk;

  anc_packet_formatter dut (
    .clk(clk), .rst(rst), .pkt_en(pkt_en), .pkt_data(pkt_data),
    .did_cfg(did_cfg), .anc_word(anc_word), .anc_valid(anc_valid),
    .anc_last(anc_last), .ovf_flag(ovf_flag)
  );

  int n_chk = 0, n_fail = 0, ovf_cnt = 0, gap_cnt = 0;
  logic [9:0] got_w[$], exp_w[$];
  bit         got_l[$], exp_l[$];
  logic [8:0] pw[$];
  bit         prev_open = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      if (anc_valid) begin
        got_w.push_back(anc_word);
        got_l.push_back(anc_last);
      end
      if (prev_open && !anc_valid) gap_cnt++;
      prev_open = anc_valid && !anc_last;
      if (ovf_flag) ovf_cnt++;
    end
  end

  function automatic logic [9:0] inv9(input logic [8:0] w);
    return {~w[8], w};
  endfunction

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expect_pkt(input logic [8:0] did);
    logic [8:0] sum = did;
    exp_w.push_back(10'h000); exp_l.push_back(1'b0);
    exp_w.push_back(10'h3FF); exp_l.push_back(1'b0);
    exp_w.push_back(10'h3FF); exp_l.push_back(1'b0);
    exp_w.push_back(inv9(did)); exp_l.push_back(1'b0);
    foreach (pw[i]) begin
      exp_w.push_back(inv9(pw[i])); exp_l.push_back(1'b0);
      sum = sum + pw[i];
    end
    exp_w.push_back(inv9(sum)); exp_l.push_back(1'b1);
  endtask

  task automatic send(input logic [8:0] da, input logic [8:0] db);
    int n = pw.size();
    @(posedge clk); #1;
    pkt_en  = 1'b1;
    did_cfg = da;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      pkt_data = pw[i];
      pkt_en   = (i < n - 1);
      if (i >= 1) did_cfg = db;
    end
  endtask

  task automatic drain(input int extra);
    for (int k = 0; k < 3000 && got_w.size() < exp_w.size(); k++) @(posedge clk);
    repeat (extra) @(posedge clk);
  endtask

  task automatic check_out(input string req);
    bit bad = 1'b0;
    int at = -1;
    n_chk++;
    if (got_w.size() != exp_w.size()) bad = 1'b1;
    else foreach (exp_w[i])
      if (!bad && (got_w[i] !== exp_w[i] || got_l[i] != exp_l[i])) begin
        bad = 1'b1;
        at = i;
      end
    if (bad) begin
      n_fail++;
      if (at < 0)
        $display("FAIL %s: actual %0d words expected %0d words", req, got_w.size(), exp_w.size());
      else
        $display("FAIL %s: word %0d actual %h/%0d expected %h/%0d", req, at,
                 got_w[at], got_l[at], exp_w[at], exp_l[at]);
    end
    got_w.delete(); got_l.delete(); exp_w.delete(); exp_l.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int r, n0;
    logic [8:0] d;
    r = $urandom(32'h00C0FFEE);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1 valid in reset", anc_valid, 0);
    check_eq("R1 last in reset", anc_last, 0);
    check_eq("R1 ovf in reset", ovf_flag, 0);
    @(posedge clk); #1; rst = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check_eq("R1 valid after reset", anc_valid, 0);

    // R2: single-word packet
    pw = {9'h0AB};
    expect_pkt(9'h141); send(9'h141, 9'h141); drain(6);
    check_out("R2 one-word packet");

    // R5: checksum wraps modulo 512
    pw = {9'h1FF, 9'h1FF};
    expect_pkt(9'h1FF); send(9'h1FF, 9'h1FF); drain(6);
    if (got_w.size() > 0) check_eq("R5 wrapped checksum", got_w[got_w.size()-1], 10'h1FD);
    check_out("R5 wrap packet");

    // R6: identifier change after first word is not used
    pw = {9'h011, 9'h022, 9'h033, 9'h044};
    expect_pkt(9'h060); send(9'h060, 9'h0FF); drain(6);
    check_out("R6 identifier latched at first word");

    // R2 R3 R4 R5: random packets
    for (int p = 0; p < 20; p++) begin
      int len = 1 + ($urandom % 60);
      bit bad3 = 1'b0;
      pw.delete();
      for (int i = 0; i < len; i++) pw.push_back(9'($urandom));
      d = 9'($urandom);
      expect_pkt(d); send(d, 9'($urandom)); drain(6);
      for (int i = 3; i < got_w.size(); i++)
        if (got_w[i][9] == got_w[i][8]) bad3 = 1'b1;
      check_eq("R3 bit 9 inverse of bit 8", bad3, 0);
      check_out("R4 random packet");
    end

    // R8: two packets back to back leave in order
    pw.delete(); for (int i = 0; i < 10; i++) pw.push_back(9'(i * 37));
    expect_pkt(9'h101); send(9'h101, 9'h101);
    pw.delete(); for (int i = 0; i < 5; i++) pw.push_back(9'(300 + i));
    expect_pkt(9'h102); send(9'h102, 9'h102);
    drain(8);
    check_out("R8 order of two packets");

    // R8: third packet while both buffers busy is dropped
    pw.delete(); for (int i = 0; i < 100; i++) pw.push_back(9'($urandom));
    expect_pkt(9'h0A0); send(9'h0A0, 9'h0A0);
    pw = {9'h001, 9'h002, 9'h003};
    expect_pkt(9'h0B0); send(9'h0B0, 9'h0B0);
    pw = {9'h1F1, 9'h1F2, 9'h1F3};
    send(9'h0C0, 9'h0C0);
    drain(40);
    check_out("R8 drop when no buffer free");
    pw = {9'h055, 9'h066, 9'h077, 9'h088};
    expect_pkt(9'h0D0); send(9'h0D0, 9'h0D0); drain(6);
    check_out("R8 packet after drop");

    // R7: 256 words overflow, 255 words fine
    n0 = ovf_cnt;
    pw.delete(); for (int i = 0; i < 256; i++) pw.push_back(9'($urandom));
    send(9'h077, 9'h077); drain(300);
    check_eq("R7 overflow pulses", ovf_cnt - n0, 1);
    check_out("R7 overflowed packet discarded");
    n0 = ovf_cnt;
    pw.delete(); for (int i = 0; i < 255; i++) pw.push_back(9'($urandom));
    expect_pkt(9'h078); send(9'h078, 9'h078); drain(8);
    check_eq("R7 no overflow at 255", ovf_cnt - n0, 0);
    check_out("R7 full-length packet");

    // R9: contiguity over the whole run
    check_eq("R9 gaps inside bursts", gap_cnt, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule